// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable cell of a sum-of-products logic fabric. Static configuration inputs decide how the cell turns its inputs into a result. The inputs are a wide sum-of-products term, one extra single product term and a set of candidate clock, set, reset and enable sources. The cell can combine the sum term with the extra term through an XOR gate and can invert the result. It then either passes the value straight through or holds it in a storage element. That element can be a D flip-flop, a T flip-flop or a transparent latch.

The cell chooses its own clock from the global clocks, a block-shared control-term clock or a local product-term clock. It can clock on one edge of either polarity or on both edges. Asynchronous set and reset are each chosen from a global line, a shared control term or a local product term, or they can be switched off. There are two outputs. One goes toward the pin driver and the other feeds back into the routing. In input-register mode the storage element samples the cell's own pin and sends that value to the feedback output, while the logic path still reaches the pin-side output.

Top module: `logic_cell`

## Requirements
- R1: With mode code 00 (bypass) and input-register mode off, both outputs equal `cfgInvert ^ sopIn ^ (cfgXorEn & ptXor)` without any clock.
- R2: With mode code 01 (D flip-flop), the feedback output takes the value of the logic function on each active edge of the selected clock and holds it between edges. The XOR and inversion are applied before storage.
- R3: With mode code 10 (T flip-flop), the stored value inverts on an active edge when the logic function is 1 and holds when it is 0.
- R4: With mode code 11 (latch), the output follows the logic function while the selected clock is high, or while it is low when `cfgClkInv` is 1. Otherwise the output holds.
- R5: In single-edge mode with `cfgClkInv` set to 1, a flip-flop captures on the falling edge of the selected clock and ignores the rising edge.
- R6: With `cfgDualEdge` set to 1, a flip-flop captures on both the rising and the falling edge of the selected clock.
- R7: With `cfgCeEn` set to 1 in D mode, an edge with `ceIn` low leaves the state unchanged. In T mode `ceIn` has no effect.
- R8: Clock select code i (i below NUM_GCLK) picks `gclk[i]`, code NUM_GCLK picks `ctClk` and code NUM_GCLK+1 picks `ptClk`. Any higher code selects no clock, so the state holds. Sources that are not selected have no effect.
- R9: Set and reset selects use code 00 for off, 01 for `gsr`, 10 for the control term (`ctSet`/`ctRst`) and 11 for the product term (`ptSet`/`ptRst`). An active selected source forces the stored value to 1 (set) or 0 (reset) at once, with no clock. A source that is not selected has no effect.
- R10: When the selected set and the selected reset are both active, the stored value is 0.
- R11: With `cfgInReg` set to 1, the storage element captures `pinIn` and drives `fbOut`, while `padOut` carries the logic function combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | NUM_GCLK | Global clocks |
| ctClk | input | 1 | Block-shared control-term clock |
| ptClk | input | 1 | Local product-term clock |
| gsr | input | 1 | Global set/reset line |
| ctSet | input | 1 | Control-term asynchronous set |
| ctRst | input | 1 | Control-term asynchronous reset |
| ptSet | input | 1 | Product-term asynchronous set |
| ptRst | input | 1 | Product-term asynchronous reset |
| ceIn | input | 1 | Clock enable (D mode only) |
| sopIn | input | 1 | Sum-of-products term |
| ptXor | input | 1 | Single product term for the XOR |
| pinIn | input | 1 | Cell's own pin value for input-register mode |
| cfgMode | input | 2 | 00 bypass, 01 D, 10 T, 11 latch |
| cfgXorEn | input | 1 | Enables the XOR with ptXor |
| cfgInvert | input | 1 | Inverts the logic function |
| cfgClkSel | input | CLK_SEL_W | Clock source select |
| cfgClkInv | input | 1 | Selects falling edge or low-transparent operation |
| cfgDualEdge | input | 1 | Capture on both clock edges |
| cfgCeEn | input | 1 | Clock enable in use |
| cfgSetSel | input | 2 | Asynchronous set source |
| cfgRstSel | input | 2 | Asynchronous reset source |
| cfgInReg | input | 1 | Input-register mode |
| padOut | output | 1 | Result toward the pin driver |
| fbOut | output | 1 | Result toward the interconnect |

## Verification
On every global clock edge, the assertions check four things: the bypass path matches the logic function, a plain D-mode flop loads the previous cycle's function, a disabled clock enable or an unused clock code freezes the state, and a global reset overrides a global set. Latch transparency, falling-edge and dual-edge capture, T-mode toggling, the control-term and product-term clocks, and input-register mode appear only in the bench's directed scenarios. Those scenarios also cover asynchronous set and reset arriving from the shared and local terms.

// File: rtl/logic_cell_pkg.sv
package logic_cell_pkg;

  typedef enum logic [1:0] {
    MODE_COMB  = 2'b00,
    MODE_DFF   = 2'b01,
    MODE_TFF   = 2'b10,
    MODE_LATCH = 2'b11
  } cellMode_e;

  typedef enum logic [1:0] {
    SRC_OFF    = 2'b00,
    SRC_GLOBAL = 2'b01,
    SRC_CTRL   = 2'b10,
    SRC_PTERM  = 2'b11
  } srcSel_e;

  // strobes handed from the control unit to the storage datapath
  typedef struct packed {
    logic edgeClk;    // single-edge flop clock, polarity applied
    logic rawClk;     // selected clock before polarity
    logic latchOpen;  // latch transparent
    logic setNow;
    logic rstNow;
    logic loadEn;     // clock enable after mode qualification
    logic dualEn;
    logic toggleMode;
    logic latchMode;
    logic combMode;
  } ctlStrobes_t;

endpackage

// File: rtl/logic_cell_ctrl.sv
module logic_cell_ctrl
  import logic_cell_pkg::*;
#(
  parameter int NUM_GCLK  = 3,
  parameter int CLK_SEL_W = $clog2(NUM_GCLK + 2)
) (
  input  logic [NUM_GCLK-1:0]  gclk,
  input  logic                 ctClk,
  input  logic                 ptClk,
  input  logic                 gsr,
  input  logic                 ctSet,
  input  logic                 ctRst,
  input  logic                 ptSet,
  input  logic                 ptRst,
  input  logic                 ceIn,
  input  cellMode_e            mode,
  input  logic [CLK_SEL_W-1:0] cfgClkSel,
  input  logic                 cfgClkInv,
  input  logic                 cfgDualEdge,
  input  logic                 cfgCeEn,
  input  srcSel_e              setSel,
  input  srcSel_e              rstSel,
  output ctlStrobes_t          strb
);

  localparam logic [CLK_SEL_W-1:0] SEL_CT = CLK_SEL_W'(NUM_GCLK);
  localparam logic [CLK_SEL_W-1:0] SEL_PT = CLK_SEL_W'(NUM_GCLK + 1);

  logic selClk;

  function automatic logic pickSrc(input srcSel_e sel, input logic g,
                                   input logic c, input logic p);
    case (sel)
      SRC_GLOBAL: return g;
      SRC_CTRL:   return c;
      SRC_PTERM:  return p;
      default:    return 1'b0;
    endcase
  endfunction

  always_comb begin
    selClk = 1'b0;
    for (int i = 0; i < NUM_GCLK; i++) begin
      if (cfgClkSel == CLK_SEL_W'(i)) selClk = gclk[i];
    end
    if (cfgClkSel == SEL_CT) selClk = ctClk;
    if (cfgClkSel == SEL_PT) selClk = ptClk;
  end

  always_comb begin
    strb.rawClk     = selClk;
    strb.edgeClk    = selClk ^ (cfgClkInv & ~cfgDualEdge);
    strb.latchOpen  = selClk ^ cfgClkInv;
    strb.setNow     = pickSrc(setSel, gsr, ctSet, ptSet);
    strb.rstNow     = pickSrc(rstSel, gsr, ctRst, ptRst);
    strb.loadEn     = !((mode == MODE_DFF) && cfgCeEn && !ceIn);
    strb.dualEn     = cfgDualEdge;
    strb.toggleMode = (mode == MODE_TFF);
    strb.latchMode  = (mode == MODE_LATCH);
    strb.combMode   = (mode == MODE_COMB);
  end

endmodule

// File: rtl/logic_cell_dp.sv
module logic_cell_dp
  import logic_cell_pkg::*;
(
  input  ctlStrobes_t strb,
  input  logic        sopIn,
  input  logic        ptXor,
  input  logic        pinIn,
  input  logic        cfgXorEn,
  input  logic        cfgInvert,
  input  logic        cfgInReg,
  output logic        padOut,
  output logic        fbOut
);

  logic logicVal, dIn, nextVal, ffQ, stored;
  logic posQ, negQ, latchQ;
  logic edgeClk, rawClk, setNow, rstNow, latchOpen;

  assign edgeClk   = strb.edgeClk;
  assign rawClk    = strb.rawClk;
  assign setNow    = strb.setNow;
  assign rstNow    = strb.rstNow;
  assign latchOpen = strb.latchOpen;

  assign logicVal = cfgInvert ^ (sopIn ^ (cfgXorEn & ptXor));
  assign dIn      = cfgInReg ? pinIn : logicVal;
  // the stored value is the XOR of a rising-side and a falling-side flop
  assign ffQ      = posQ ^ negQ;
  assign nextVal  = strb.toggleMode ? (ffQ ^ dIn) : dIn;

  always_ff @(posedge edgeClk or posedge rstNow or posedge setNow) begin
    if (rstNow)           posQ <= 1'b0;
    else if (setNow)      posQ <= 1'b1;
    else if (strb.loadEn) posQ <= nextVal ^ negQ;
  end

  always_ff @(negedge rawClk or posedge rstNow or posedge setNow) begin
    if (rstNow)           negQ <= 1'b0;
    else if (setNow)      negQ <= 1'b0;
    else if (!strb.dualEn) negQ <= 1'b0;
    else if (strb.loadEn) negQ <= nextVal ^ posQ;
  end

  always_latch begin
    if (rstNow)         latchQ <= 1'b0;
    else if (setNow)    latchQ <= 1'b1;
    else if (latchOpen) latchQ <= dIn;
  end

  always_comb begin
    if (strb.combMode)       stored = dIn;
    else if (strb.latchMode) stored = latchQ;
    else                     stored = ffQ;
  end

  assign fbOut  = stored;
  assign padOut = cfgInReg ? logicVal : stored;

endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import logic_cell_pkg::*;
#(
  parameter int NUM_GCLK  = 3,
  parameter int CLK_SEL_W = $clog2(NUM_GCLK + 2)
) (
  input  logic [NUM_GCLK-1:0]  gclk,
  input  logic                 ctClk,
  input  logic                 ptClk,
  input  logic                 gsr,
  input  logic                 ctSet,
  input  logic                 ctRst,
  input  logic                 ptSet,
  input  logic                 ptRst,
  input  logic                 ceIn,
  input  logic                 sopIn,
  input  logic                 ptXor,
  input  logic                 pinIn,
  input  logic [1:0]           cfgMode,
  input  logic                 cfgXorEn,
  input  logic                 cfgInvert,
  input  logic [CLK_SEL_W-1:0] cfgClkSel,
  input  logic                 cfgClkInv,
  input  logic                 cfgDualEdge,
  input  logic                 cfgCeEn,
  input  logic [1:0]           cfgSetSel,
  input  logic [1:0]           cfgRstSel,
  input  logic                 cfgInReg,
  output logic                 padOut,
  output logic                 fbOut
);

  ctlStrobes_t strb;

  logic_cell_ctrl #(.NUM_GCLK(NUM_GCLK), .CLK_SEL_W(CLK_SEL_W)) u_ctrl (
    .gclk(gclk), .ctClk(ctClk), .ptClk(ptClk),
    .gsr(gsr), .ctSet(ctSet), .ctRst(ctRst), .ptSet(ptSet), .ptRst(ptRst),
    .ceIn(ceIn), .mode(cellMode_e'(cfgMode)),
    .cfgClkSel(cfgClkSel), .cfgClkInv(cfgClkInv), .cfgDualEdge(cfgDualEdge),
    .cfgCeEn(cfgCeEn), .setSel(srcSel_e'(cfgSetSel)),
    .rstSel(srcSel_e'(cfgRstSel)), .strb(strb)
  );

  logic_cell_dp u_dp (
    .strb(strb), .sopIn(sopIn), .ptXor(ptXor), .pinIn(pinIn),
    .cfgXorEn(cfgXorEn), .cfgInvert(cfgInvert), .cfgInReg(cfgInReg),
    .padOut(padOut), .fbOut(fbOut)
  );

endmodule

// File: rtl/logic_cell_chk.sv
module logic_cell_chk #(
  parameter int NUM_GCLK  = 3,
  parameter int CLK_SEL_W = $clog2(NUM_GCLK + 2)
) (
  input logic [NUM_GCLK-1:0]  gclk,
  input logic                 gsr,
  input logic                 ctSet,
  input logic                 ctRst,
  input logic                 ptSet,
  input logic                 ptRst,
  input logic                 ceIn,
  input logic                 sopIn,
  input logic                 ptXor,
  input logic [1:0]           cfgMode,
  input logic                 cfgXorEn,
  input logic                 cfgInvert,
  input logic [CLK_SEL_W-1:0] cfgClkSel,
  input logic                 cfgClkInv,
  input logic                 cfgDualEdge,
  input logic                 cfgCeEn,
  input logic [1:0]           cfgSetSel,
  input logic [1:0]           cfgRstSel,
  input logic                 cfgInReg,
  input logic                 padOut,
  input logic                 fbOut
);

  logic clk, anyAsync, dExp, plainD;
  logic [CLK_SEL_W+12:0] cfgBus;

  assign clk      = gclk[0];
  assign anyAsync = gsr | ctSet | ctRst | ptSet | ptRst;
  assign dExp     = cfgInvert ^ sopIn ^ (cfgXorEn & ptXor);
  assign cfgBus   = {cfgMode, cfgXorEn, cfgInvert, cfgClkSel, cfgClkInv,
                     cfgDualEdge, cfgCeEn, cfgSetSel, cfgRstSel, cfgInReg};
  assign plainD   = (cfgMode == 2'b01) && (cfgClkSel == '0) && !cfgClkInv &&
                    !cfgDualEdge && (cfgSetSel == 2'b00) &&
                    (cfgRstSel == 2'b00) && !cfgInReg;

  AST_COMB_PATH: assert property (@(posedge clk) disable iff (anyAsync)
    (cfgMode == 2'b00 && !cfgInReg) |-> (padOut == dExp)); // R1

  AST_D_CAPTURE: assert property (@(posedge clk) disable iff (anyAsync)
    (plainD && (!cfgCeEn || ceIn)) |=>
      ((fbOut == $past(dExp)) || !$stable(cfgBus))); // R2

  AST_CE_HOLD: assert property (@(posedge clk) disable iff (anyAsync)
    (plainD && cfgCeEn && !ceIn) |=> ($stable(fbOut) || !$stable(cfgBus))); // R7

  AST_NOCLK_HOLD: assert property (@(posedge clk) disable iff (anyAsync)
    ((cfgMode == 2'b01 || cfgMode == 2'b10) &&
     (int'(cfgClkSel) > NUM_GCLK + 1) &&
     cfgSetSel == 2'b00 && cfgRstSel == 2'b00)
      |=> ($stable(fbOut) || !$stable(cfgBus))); // R8

  always @(negedge clk) begin
    if (cfgMode != 2'b00 && cfgRstSel == 2'b01 && gsr)
      AST_RST_WINS: assert (fbOut == 1'b0); // R10
  end

endmodule

bind logic_cell logic_cell_chk #(.NUM_GCLK(NUM_GCLK), .CLK_SEL_W(CLK_SEL_W)) u_chk (.*);

// File: tb/logic_cell_bench.sv
`timescale 1ns/1ps
module logic_cell_bench;

  localparam int NUM_GCLK  = 3;
  localparam int CLK_SEL_W = $clog2(NUM_GCLK + 2);
  localparam int WD_CYCLES = 20000;

  // {xorEn, invert, sop, pt, expected}
  localparam logic [4:0] COMB_VEC [8] = '{
    5'b00111, 5'b00010, 5'b01001, 5'b01110,
    5'b10110, 5'b10011, 5'b11100, 5'b11111
  };

  logic clk0 = 1'b0, gclk1, gclk2;
  logic [NUM_GCLK-1:0] gclk;
  logic ctClk, ptClk, gsr, ctSet, ctRst, ptSet, ptRst, ceIn;
  logic sopIn, ptXor, pinIn;
  logic [1:0] cfgMode, cfgSetSel, cfgRstSel;
  logic cfgXorEn, cfgInvert, cfgClkInv, cfgDualEdge, cfgCeEn, cfgInReg;
  logic [CLK_SEL_W-1:0] cfgClkSel;
  logic padOut, fbOut;
  int nTests = 0, nFail = 0;

  always #4 clk0 = ~clk0;
  assign gclk = {gclk2, gclk1, clk0};

  logic_cell #(.NUM_GCLK(NUM_GCLK)) u_logic_cell (
    .gclk(gclk), .ctClk(ctClk), .ptClk(ptClk), .gsr(gsr),
    .ctSet(ctSet), .ctRst(ctRst), .ptSet(ptSet), .ptRst(ptRst),
    .ceIn(ceIn), .sopIn(sopIn), .ptXor(ptXor), .pinIn(pinIn),
    .cfgMode(cfgMode), .cfgXorEn(cfgXorEn), .cfgInvert(cfgInvert),
    .cfgClkSel(cfgClkSel), .cfgClkInv(cfgClkInv), .cfgDualEdge(cfgDualEdge),
    .cfgCeEn(cfgCeEn), .cfgSetSel(cfgSetSel), .cfgRstSel(cfgRstSel),
    .cfgInReg(cfgInReg), .padOut(padOut), .fbOut(fbOut)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk0); #1;
  endtask

  task automatic waitLow();
    @(negedge clk0); #1;
  endtask

  task automatic pulse(ref logic c);
    #0.5 c = 1'b1;
    #0.5 c = 1'b0;
  endtask

  initial begin
    #(WD_CYCLES * 8);
    nTests++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    gclk1 = 0; gclk2 = 0; ctClk = 0; ptClk = 0;
    ctSet = 0; ctRst = 0; ptSet = 0; ptRst = 0; ceIn = 0;
    sopIn = 0; ptXor = 0; pinIn = 0;
    cfgMode = 2'b01; cfgXorEn = 0; cfgInvert = 0; cfgClkSel = '0;
    cfgClkInv = 0; cfgDualEdge = 0; cfgCeEn = 0; cfgInReg = 0;
    gsr = 1; cfgRstSel = 2'b01; cfgSetSel = 2'b00;

    // reset state and priority
    #1 check("R9 global reset", fbOut, 1'b0);
    check("R9 global reset pad", padOut, 1'b0);
    cfgSetSel = 2'b01;
    #0.5 check("R10 reset beats set", fbOut, 1'b0);
    gsr = 0;
    #0.5 cfgRstSel = 2'b00; gsr = 1;
    #0.5 check("R9 global set", fbOut, 1'b1);
    gsr = 0; cfgSetSel = 2'b00;
    tick();

    // combinational vector table
    cfgMode = 2'b00;
    for (int i = 0; i < 8; i++) begin
      {cfgXorEn, cfgInvert, sopIn, ptXor} = COMB_VEC[i][4:1];
      #1;
      check("R1 bypass pad", padOut, COMB_VEC[i][0]);
      check("R1 bypass fb", fbOut, COMB_VEC[i][0]);
    end

    // D flip-flop
    cfgMode = 2'b01; cfgXorEn = 0; cfgInvert = 0; ptXor = 0; sopIn = 1;
    tick(); check("R2 D capture 1", fbOut, 1'b1);
    sopIn = 0;
    #2 check("R2 D holds between edges", fbOut, 1'b1);
    tick(); check("R2 D capture 0", fbOut, 1'b0);
    cfgXorEn = 1; ptXor = 1; sopIn = 0;
    tick(); check("R2 XOR before storage", fbOut, 1'b1);
    cfgXorEn = 0; ptXor = 0;

    // clock enable
    cfgCeEn = 1; ceIn = 0; sopIn = 0;
    tick(); check("R7 CE low holds", fbOut, 1'b1);
    ceIn = 1;
    tick(); check("R7 CE high loads", fbOut, 1'b0);
    cfgCeEn = 0; ceIn = 0; sopIn = 1;
    tick(); check("R7 CE unused loads", fbOut, 1'b1);

    // T flip-flop with CE ignored
    cfgMode = 2'b10; cfgCeEn = 1; ceIn = 0; sopIn = 1;
    tick(); check("R3 T toggle, R7 CE ignored", fbOut, 1'b0);
    tick(); check("R3 T toggle back", fbOut, 1'b1);
    sopIn = 0;
    tick(); check("R3 T hold", fbOut, 1'b1);
    cfgCeEn = 0; cfgMode = 2'b01;

    // falling-edge capture
    sopIn = 0; cfgClkInv = 1;
    #1 check("R5 no capture on polarity change", fbOut, 1'b1);
    waitLow(); check("R5 falling edge capture", fbOut, 1'b0);
    sopIn = 1;
    tick(); check("R5 rising edge ignored", fbOut, 1'b0);
    waitLow(); cfgClkInv = 0;
    check("R5 second falling capture", fbOut, 1'b1);

    // dual-edge capture
    cfgDualEdge = 1; sopIn = 0;
    tick(); check("R6 rising capture", fbOut, 1'b0);
    sopIn = 1;
    waitLow(); check("R6 falling capture", fbOut, 1'b1);
    sopIn = 0;
    tick(); check("R6 rising capture again", fbOut, 1'b0);
    sopIn = 1;
    waitLow(); check("R6 falling capture again", fbOut, 1'b1);
    cfgDualEdge = 0; sopIn = 0;
    cfgRstSel = 2'b10; ctRst = 1;
    #1 check("R9 control-term reset", fbOut, 1'b0);
    ctRst = 0; cfgRstSel = 2'b00;

    // clock source selection
    waitLow();
    cfgClkSel = CLK_SEL_W'(NUM_GCLK); sopIn = 1;
    tick(); check("R8 unselected global ignored", fbOut, 1'b0);
    pulse(ctClk); check("R8 control-term clock", fbOut, 1'b1);
    cfgClkSel = CLK_SEL_W'(NUM_GCLK + 1); sopIn = 0;
    pulse(ctClk); check("R8 ct clock not selected", fbOut, 1'b1);
    pulse(ptClk); check("R8 product-term clock", fbOut, 1'b0);
    cfgClkSel = CLK_SEL_W'(1); sopIn = 1;
    pulse(gclk1); check("R8 global clock 1", fbOut, 1'b1);
    cfgClkSel = CLK_SEL_W'(NUM_GCLK + 2); sopIn = 0;
    pulse(gclk1); pulse(gclk2); pulse(ctClk); pulse(ptClk);
    tick(); check("R8 unused code holds", fbOut, 1'b1);

    // asynchronous set/reset sources
    cfgSetSel = 2'b10; cfgRstSel = 2'b11;
    ptRst = 1;
    #1 check("R9 product-term reset", fbOut, 1'b0);
    ptRst = 0; ctSet = 1;
    #1 check("R9 control-term set", fbOut, 1'b1);
    ctSet = 0;
    #1 check("R9 set released holds", fbOut, 1'b1);
    ptRst = 1;
    #1 ctSet = 1;
    #1 check("R10 reset held against set", fbOut, 1'b0);
    ctSet = 0;
    #1 ptRst = 0;
    #1 check("R10 after both release", fbOut, 1'b0);
    cfgSetSel = 2'b00; ctSet = 1;
    #1 check("R9 off source ignored", fbOut, 1'b0);
    ctSet = 0; cfgSetSel = 2'b11; ptSet = 1;
    #1 check("R9 product-term set", fbOut, 1'b1);
    ptSet = 0; cfgSetSel = 2'b00;

    // transparent latch
    cfgMode = 2'b11; cfgClkSel = CLK_SEL_W'(1); gclk1 = 0;
    ptRst = 1;
    #1 check("R4 latch reset", fbOut, 1'b0);
    ptRst = 0; sopIn = 1;
    #1 check("R4 latch closed holds", fbOut, 1'b0);
    gclk1 = 1;
    #1 check("R4 latch open passes 1", fbOut, 1'b1);
    sopIn = 0;
    #1 check("R4 latch open passes 0", fbOut, 1'b0);
    gclk1 = 0;
    #1 sopIn = 1;
    #1 check("R4 latch closed again", fbOut, 1'b0);
    cfgClkInv = 1;
    #1 check("R4 inverted open on low", fbOut, 1'b1);
    gclk1 = 1;
    #1 sopIn = 0;
    #1 check("R4 inverted closed on high", fbOut, 1'b1);

    // input-register mode
    waitLow();
    cfgClkInv = 0; cfgClkSel = '0; gclk1 = 0;
    cfgMode = 2'b01; cfgInReg = 1;
    ptRst = 1;
    #0.5 ptRst = 0; cfgRstSel = 2'b00;
    pinIn = 1; sopIn = 0;
    #0.5 check("R11 pad carries logic", padOut, 1'b0);
    tick(); check("R11 pin registered", fbOut, 1'b1);
    check("R11 pad still logic", padOut, 1'b0);
    sopIn = 1;
    #1 check("R11 pad follows logic", padOut, 1'b1);
    check("R11 fb unaffected by logic", fbOut, 1'b1);
    pinIn = 0;
    tick(); check("R11 pin registered 0", fbOut, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule